// File: doc/BRIEF.md
# Channel Program Command Sequencer

This block runs a chain of eight-byte channel command words (CCWs) held in memory, moving bytes between a byte-stream device and memory without CPU involvement. Software places a program in memory and pulses `start` with the address of the first word. The sequencer fetches each word one byte at a time over a shared memory port, decodes it, and then streams data. Read commands move device bytes into memory, and write commands move memory bytes out to the device.

Per-word flag bits steer the walk through the program. Data chaining carries one command across several buffers. Command chaining starts a fresh command on the same device. Skip consumes read data without storing it. Suppress-length tolerates a record whose size differs from the programmed count. A transfer-in-channel word redirects fetching to another address. When the program finishes, or when an error stops it, the block raises `done` for one cycle and presents a status code on `status`.

Top module: `chan_seq`

## Requirements
- R1: After reset `busy`, `done`, `mem_req`, `dev_in_ready`, `dev_out_valid` and `dev_start` are low and `status` is 0.
- R2: A `start` pulse while idle loads `start_addr` as the first CCW address, and `busy` is high at the next cycle. A `start` while busy has no effect on the running program.
- R3: A CCW is eight bytes at ascending addresses: byte 0 command (0x01 write, 0x02 read, 0x08 transfer-in-channel), bytes 1–3 data address most significant first, byte 4 flags, byte 5 unused, bytes 6–7 byte count most significant first. A write command reads memory from the data address upward and delivers each byte on the device output handshake, honouring `dev_out_ready`.
- R4: A read command stores each accepted device byte at ascending memory addresses starting at the data address.
- R5: Flag bit 7 (data chain): when a segment's count is used up, the next CCW supplies a new address, count and flags, while its command byte is ignored and the command continues without a new `dev_start`.
- R6: Flag bit 6 (command chain): when a command ends without a length stop, the next CCW starts a new command and `dev_start` pulses once for it.
- R7: Flag bit 4 (skip) on a read: device bytes are accepted but nothing is written to memory.
- R8: On a read, `dev_in_last` arriving before the final byte of the command (short record), or the final byte arriving without it (long record), is a length mismatch. With flag bit 5 (suppress length) clear, this ends the program with status 1 and no further chaining. With bit 5 set, the command ends normally and bit 6 decides whether chaining continues.
- R9: A transfer-in-channel word makes fetching resume at its address field, and it moves no data.
- R10: Two transfer-in-channel words fetched in a row end the program with status 2.
- R11: A new command whose code is neither read nor write, or any non-branch CCW with a count of zero, ends the program with status 2.
- R12: A program that ends without an error reports status 0. `done` is high for exactly one cycle, `busy` is low in the next cycle, and `status` changes only in the cycle where `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a channel program |
| start_addr | input | 24 | Address of the first CCW |
| busy | output | 1 | A program is running |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 ok, 1 incorrect length, 2 program error |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Access is a write |
| mem_addr | output | 24 | Byte address |
| mem_wdata | output | 8 | Write data |
| mem_rdata | input | 8 | Read data, valid the cycle after a read request |
| dev_start | output | 1 | Pulse as a new device command begins |
| dev_cmd | output | 8 | Command code accompanying `dev_start` |
| dev_in_valid | input | 1 | Device offers a byte |
| dev_in_data | input | 8 | Device byte |
| dev_in_last | input | 1 | Offered byte ends the device record |
| dev_in_ready | output | 1 | Sequencer accepts the device byte |
| dev_out_valid | output | 1 | Sequencer offers a byte to the device |
| dev_out_data | output | 8 | Byte to the device |
| dev_out_ready | input | 1 | Device takes the byte |

## Verification
`busy` rises in the first cycle after the edge that samples `start`. Each CCW fetch takes eight request cycles plus one cycle of read latency before decode, and `done` comes one state after the last byte or the failing decode. The bench drives inputs and samples outputs on the falling edge. It checks `busy` one cycle after `start`, polls for the single `done` cycle, and reads `status` in that cycle. It compares memory and device captures only after `done`, then confirms that `done` and `busy` are low one cycle later. A sweep over record lengths 1 to 6 against a count of 4, with suppress-length on and off, predicts the bytes stored, the status and whether the chained write runs.

// File: rtl/chan_seq_pkg.sv
package chan_seq_pkg;
  localparam int CCW_ADDR_W = 24;
  localparam int CCW_CNT_W  = 16;
  localparam int CCW_NBYTES = 8;

  localparam logic [7:0] OP_WRITE = 8'h01;
  localparam logic [7:0] OP_READ  = 8'h02;
  localparam logic [7:0] OP_TIC   = 8'h08;

  localparam int FL_CD   = 7;
  localparam int FL_CC   = 6;
  localparam int FL_SLI  = 5;
  localparam int FL_SKIP = 4;

  typedef enum logic [1:0] {
    ST_OK      = 2'd0,
    ST_INCLEN  = 2'd1,
    ST_PROGERR = 2'd2
  } seq_status_e;

  typedef enum logic [2:0] {
    S_IDLE, S_FETCH, S_DECODE, S_RDDEV, S_MRD, S_MWAIT, S_WRDEV, S_DONE
  } seq_state_e;

  typedef struct packed {
    logic [7:0]            op;
    logic [CCW_ADDR_W-1:0] addr;
    logic                  cd;
    logic                  cc;
    logic                  sli;
    logic                  skip;
    logic [CCW_CNT_W-1:0]  cnt;
  } ccw_t;

  // byte 0 sits in the most significant lane of the raw image
  function automatic ccw_t ccw_from_bytes(input logic [8*CCW_NBYTES-1:0] raw);
    ccw_t w;
    w.op   = raw[63:56];
    w.addr = raw[55:32];
    w.cd   = raw[24 + FL_CD];
    w.cc   = raw[24 + FL_CC];
    w.sli  = raw[24 + FL_SLI];
    w.skip = raw[24 + FL_SKIP];
    w.cnt  = raw[15:0];
    return w;
  endfunction

  // read length mismatch: early end marker, or last counted byte without one
  function automatic logic rd_len_bad(input logic last, input logic cnt_one, input logic cd);
    return (last && (!cnt_one || cd)) || (!last && cnt_one && !cd);
  endfunction
endpackage

// File: rtl/chan_seq_fetch.sv
module chan_seq_fetch #(
  parameter int ADDR_W = 24,
  parameter int NBYTES = 8,
  localparam int IDX_W = $clog2(NBYTES + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic [ADDR_W-1:0]   base,
  output logic                rd_req,
  output logic [ADDR_W-1:0]   rd_addr,
  input  logic [7:0]          rd_data,
  output logic [8*NBYTES-1:0] raw,
  output logic                fetched
);
  logic [IDX_W-1:0] issue_q;
  logic [IDX_W-1:0] pidx_q;
  logic             pend_q;

  assign rd_req  = enable && (issue_q < IDX_W'(NBYTES));
  assign rd_addr = base + ADDR_W'(issue_q);
  assign fetched = pend_q && (pidx_q == IDX_W'(NBYTES - 1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      issue_q <= '0;
      pidx_q  <= '0;
      pend_q  <= 1'b0;
      raw     <= '0;
    end else begin
      if (!enable)     issue_q <= '0;
      else if (rd_req) issue_q <= issue_q + 1'b1;
      pend_q <= rd_req;
      pidx_q <= issue_q;
      if (pend_q) raw[(NBYTES - 1 - int'(pidx_q)) * 8 +: 8] <= rd_data;
    end
  end

  // R3: a captured byte always follows a request one cycle earlier
  fetch_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |=> pend_q);
endmodule

// File: rtl/chan_seq_ccw_unpack.sv
module chan_seq_ccw_unpack
  import chan_seq_pkg::*;
(
  input  logic [8*CCW_NBYTES-1:0] raw,
  output ccw_t                    ccw,
  output logic                    is_tic,
  output logic                    op_ok
);
  assign ccw    = ccw_from_bytes(raw);
  assign is_tic = (ccw.op == OP_TIC);
  assign op_ok  = (ccw.op == OP_READ) || (ccw.op == OP_WRITE);
endmodule

// File: rtl/chan_seq_len_judge.sv
module chan_seq_len_judge
  import chan_seq_pkg::*;
(
  input  logic is_read,
  input  logic last,
  input  logic cnt_one,
  input  logic cd,
  input  logic cc,
  input  logic sli,
  output logic chain_data,
  output logic chain_cmd,
  output logic stop_len,
  output logic finish_ok
);
  logic ended;
  logic len_bad;

  always_comb begin
    if (is_read) begin
      ended   = last || (cnt_one && !cd);
      len_bad = rd_len_bad(last, cnt_one, cd);
    end else begin
      ended   = cnt_one && !cd;
      len_bad = 1'b0;
    end
    chain_data = cnt_one && cd && !(is_read && last);
    stop_len   = ended && len_bad && !sli;
    chain_cmd  = ended && !stop_len && cc;
    finish_ok  = ended && !stop_len && !cc;
  end
endmodule

// File: rtl/chan_seq.sv
module chan_seq
  import chan_seq_pkg::*;
#(
  parameter int ADDR_W = CCW_ADDR_W,
  parameter int CNT_W  = CCW_CNT_W,
  parameter int NBYTES = CCW_NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              busy,
  output logic              done,
  output logic [1:0]        status,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              dev_start,
  output logic [7:0]        dev_cmd,
  input  logic              dev_in_valid,
  input  logic [7:0]        dev_in_data,
  input  logic              dev_in_last,
  output logic              dev_in_ready,
  output logic              dev_out_valid,
  output logic [7:0]        dev_out_data,
  input  logic              dev_out_ready
);
  seq_state_e        state_q;
  seq_status_e       status_q;
  logic [ADDR_W-1:0] ccw_ptr_q, cur_addr_q;
  logic [CNT_W-1:0]  cur_cnt_q;
  logic              cur_cd_q, cur_cc_q, cur_sli_q, cur_skip_q;
  logic [7:0]        op_q, out_q;
  logic              dchain_q, prev_tic_q;

  logic                f_req, f_done;
  logic [ADDR_W-1:0]   f_addr;
  logic [8*NBYTES-1:0] f_raw;
  ccw_t                dec;
  logic                dec_tic, dec_op_ok;
  logic                j_cdata, j_ccmd, j_stop, j_fin;

  chan_seq_fetch #(.ADDR_W(ADDR_W), .NBYTES(NBYTES)) fetch_i (
    .clk(clk), .rst_n(rst_n), .enable(state_q == S_FETCH), .base(ccw_ptr_q),
    .rd_req(f_req), .rd_addr(f_addr), .rd_data(mem_rdata),
    .raw(f_raw), .fetched(f_done));

  chan_seq_ccw_unpack unpack_i (.raw(f_raw), .ccw(dec), .is_tic(dec_tic), .op_ok(dec_op_ok));

  chan_seq_len_judge judge_i (
    .is_read(state_q == S_RDDEV), .last(dev_in_last),
    .cnt_one(cur_cnt_q == CNT_W'(1)), .cd(cur_cd_q), .cc(cur_cc_q), .sli(cur_sli_q),
    .chain_data(j_cdata), .chain_cmd(j_ccmd), .stop_len(j_stop), .finish_ok(j_fin));

  // named events for the assertions
  logic in_decode, dec_bad, tic_twice, byte_fire, stop_len_ev;
  logic [7:0] eff_op;
  assign in_decode   = (state_q == S_DECODE);
  assign eff_op      = dchain_q ? op_q : dec.op;
  assign dec_bad     = (!dchain_q && !dec_op_ok) || (dec.cnt == '0);
  assign tic_twice   = in_decode && dec_tic && prev_tic_q;
  assign byte_fire   = ((state_q == S_RDDEV) && dev_in_valid) ||
                       ((state_q == S_WRDEV) && dev_out_ready);
  assign stop_len_ev = byte_fire && j_stop;

  assign busy          = (state_q != S_IDLE);
  assign done          = (state_q == S_DONE);
  assign status        = status_q;
  assign dev_start     = in_decode && !dec_tic && !dchain_q && !dec_bad;
  assign dev_cmd       = dec.op;
  assign dev_in_ready  = (state_q == S_RDDEV);
  assign dev_out_valid = (state_q == S_WRDEV);
  assign dev_out_data  = out_q;
  assign mem_wdata     = dev_in_data;

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    mem_addr = cur_addr_q;
    case (state_q)
      S_FETCH: begin mem_req = f_req; mem_addr = f_addr; end
      S_RDDEV: begin mem_req = dev_in_valid && !cur_skip_q; mem_we = 1'b1; end
      S_MRD:   mem_req = 1'b1;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      status_q   <= ST_OK;
      ccw_ptr_q  <= '0;
      cur_addr_q <= '0;
      cur_cnt_q  <= '0;
      cur_cd_q   <= 1'b0;
      cur_cc_q   <= 1'b0;
      cur_sli_q  <= 1'b0;
      cur_skip_q <= 1'b0;
      op_q       <= '0;
      out_q      <= '0;
      dchain_q   <= 1'b0;
      prev_tic_q <= 1'b0;
    end else begin
      case (state_q)
        S_IDLE: if (start) begin
          ccw_ptr_q  <= start_addr;
          dchain_q   <= 1'b0;
          prev_tic_q <= 1'b0;
          state_q    <= S_FETCH;
        end
        S_FETCH: if (f_done) state_q <= S_DECODE;
        S_DECODE: begin
          if (dec_tic) begin
            if (prev_tic_q) begin
              status_q <= ST_PROGERR;
              state_q  <= S_DONE;
            end else begin
              ccw_ptr_q  <= ADDR_W'(dec.addr);
              prev_tic_q <= 1'b1;
              state_q    <= S_FETCH;
            end
          end else begin
            prev_tic_q <= 1'b0;
            ccw_ptr_q  <= ccw_ptr_q + ADDR_W'(NBYTES);
            if (dec_bad) begin
              status_q <= ST_PROGERR;
              state_q  <= S_DONE;
            end else begin
              op_q       <= eff_op;
              cur_addr_q <= ADDR_W'(dec.addr);
              cur_cnt_q  <= CNT_W'(dec.cnt);
              cur_cd_q   <= dec.cd;
              cur_cc_q   <= dec.cc;
              cur_sli_q  <= dec.sli;
              cur_skip_q <= dec.skip;
              state_q    <= (eff_op == OP_READ) ? S_RDDEV : S_MRD;
            end
          end
        end
        S_MRD:   state_q <= S_MWAIT;
        S_MWAIT: begin out_q <= mem_rdata; state_q <= S_WRDEV; end
        S_RDDEV, S_WRDEV: if (byte_fire) begin
          cur_addr_q <= cur_addr_q + 1'b1;
          cur_cnt_q  <= cur_cnt_q - 1'b1;
          if (j_cdata) begin
            dchain_q <= 1'b1;
            state_q  <= S_FETCH;
          end else if (j_ccmd) begin
            dchain_q <= 1'b0;
            state_q  <= S_FETCH;
          end else if (j_stop) begin
            status_q <= ST_INCLEN;
            state_q  <= S_DONE;
          end else if (j_fin) begin
            status_q <= ST_OK;
            state_q  <= S_DONE;
          end else if (state_q == S_WRDEV) begin
            state_q <= S_MRD;
          end
        end
        S_DONE:  state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // R12
  done_then_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy && !done);
  // R12
  status_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(status) |-> done);
  // R10
  tic_twice_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tic_twice |=> done && (status == 2'(ST_PROGERR)));
  // R8
  stop_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_len_ev |=> done && (status == 2'(ST_INCLEN)));
  // R4
  mem_wr_on_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (dev_in_valid && dev_in_ready));
  // R3
  port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(dev_in_ready && dev_out_valid));
  // R11
  cnt_live_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dev_in_ready || dev_out_valid) |-> (cur_cnt_q != '0));
endmodule

// File: tb/chan_seq_tb_top.sv
`timescale 1ns/1ps
module chan_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        start = 1'b0;
  logic [23:0] start_addr = '0;
  logic        busy, done;
  logic [1:0]  status;
  logic        mem_req, mem_we;
  logic [23:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        dev_start;
  logic [7:0]  dev_cmd;
  logic        dev_in_valid, dev_in_last, dev_in_ready;
  logic [7:0]  dev_in_data;
  logic        dev_out_valid, dev_out_ready;
  logic [7:0]  dev_out_data;

  chan_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .busy(busy), .done(done), .status(status),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dev_start(dev_start), .dev_cmd(dev_cmd),
    .dev_in_valid(dev_in_valid), .dev_in_data(dev_in_data),
    .dev_in_last(dev_in_last), .dev_in_ready(dev_in_ready),
    .dev_out_valid(dev_out_valid), .dev_out_data(dev_out_data),
    .dev_out_ready(dev_out_ready));

  int checks = 0;
  int fails  = 0;

  // memory model: one-cycle read latency
  logic [7:0] mem [0:1023];
  always @(posedge clk)
    if (mem_req) begin
      if (mem_we) mem[mem_addr[9:0]] <= mem_wdata;
      else        mem_rdata <= mem[mem_addr[9:0]];
    end

  // device input model: a record of rec_len bytes, seed+index
  int         rec_len = 0;
  int         idx = 0;
  logic [7:0] in_seed = '0;
  assign dev_in_valid = (idx < rec_len);
  assign dev_in_data  = in_seed + 8'(idx);
  assign dev_in_last  = (idx == rec_len - 1);
  always @(posedge clk)
    if (!rst_n || dev_start) idx <= 0;
    else if (dev_in_valid && dev_in_ready) idx <= idx + 1;

  // device output model and command counter
  logic       slow_rdy = 1'b0;
  int         cyc = 0;
  logic [7:0] out_buf [0:255];
  int         out_n = 0;
  int         starts = 0;
  assign dev_out_ready = slow_rdy ? cyc[0] : 1'b1;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (dev_out_valid && dev_out_ready) begin
      out_buf[out_n[7:0]] <= dev_out_data;
      out_n <= out_n + 1;
    end
    if (dev_start) starts <= starts + 1;
  end

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 13 + 5);
  endfunction

  task automatic checkv(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 1024; i++) mem[i] = pat(i);
  endtask

  task automatic put_ccw(input int a, input logic [7:0] op, input logic [23:0] da,
                         input logic [7:0] fl, input logic [15:0] cnt);
    mem[a]   = op;
    mem[a+1] = da[23:16];
    mem[a+2] = da[15:8];
    mem[a+3] = da[7:0];
    mem[a+4] = fl;
    mem[a+5] = 8'h00;
    mem[a+6] = cnt[15:8];
    mem[a+7] = cnt[7:0];
  endtask

  task automatic run_prog(input logic [23:0] a, input bit extra, output int st);
    int n;
    @(negedge clk);
    start = 1'b1; start_addr = a;
    @(negedge clk);
    start = 1'b0;
    checkv("R2 busy one cycle after start", int'(busy), 1);
    n = 0;
    while (!done && n < 4000) begin
      @(negedge clk);
      n++;
      if (extra && n == 20) begin start = 1'b1; start_addr = 24'h40; end
      if (extra && n == 21) start = 1'b0;
    end
    checkv("R12 done reached", int'(done), 1);
    st = int'(status);
    @(negedge clk);
    checkv("R12 done lasts one cycle, busy drops", int'(done || busy), 0);
  endtask

  localparam logic [7:0] F_CD = 8'h80, F_CC = 8'h40, F_SLI = 8'h20, F_SKIP = 8'h10;

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R12 watchdog: got 0 expected 1");
    finish_run();
  end

  initial begin
    int st, o0, s0, exp_n, exp_st;
    clear_mem();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkv("R1 busy", int'(busy), 0);
    checkv("R1 done", int'(done), 0);
    checkv("R1 status", int'(status), 0);
    checkv("R1 mem_req", int'(mem_req), 0);
    checkv("R1 device handshakes", int'(dev_in_ready || dev_out_valid || dev_start), 0);

    // R3 R5: write gathered over two buffers, command byte of chained word ignored
    clear_mem(); slow_rdy = 1'b1;
    put_ccw(0, 8'h01, 24'h100, F_CD, 16'd3);
    put_ccw(8, 8'h02, 24'h180, 8'h00, 16'd2);
    o0 = out_n; s0 = starts;
    run_prog(24'h0, 1'b0, st);
    checkv("R12 write status", st, 0);
    checkv("R5 one device command", starts - s0, 1);
    checkv("R3 bytes out", out_n - o0, 5);
    for (int k = 0; k < 3; k++) checkv("R3 gather part 1", int'(out_buf[o0+k]), int'(pat(256 + k)));
    for (int k = 0; k < 2; k++) checkv("R5 gather part 2", int'(out_buf[o0+3+k]), int'(pat(384 + k)));
    slow_rdy = 1'b0;

    // R4 R5: read scattered over two buffers
    clear_mem(); rec_len = 5; in_seed = 8'h40;
    put_ccw(0, 8'h02, 24'h200, F_CD, 16'd2);
    put_ccw(8, 8'h01, 24'h240, 8'h00, 16'd3);
    run_prog(24'h0, 1'b0, st);
    checkv("R12 read status", st, 0);
    checkv("R4 scatter b0", int'(mem[512]), 8'h40);
    checkv("R4 scatter b1", int'(mem[513]), 8'h41);
    checkv("R4 untouched after segment", int'(mem[514]), int'(pat(514)));
    for (int k = 0; k < 3; k++) checkv("R5 scatter seg2", int'(mem[576+k]), 8'h42 + k);

    // R7: skip read stores nothing
    clear_mem(); rec_len = 4; in_seed = 8'h90;
    put_ccw(0, 8'h02, 24'h280, F_SKIP, 16'd4);
    run_prog(24'h0, 1'b0, st);
    checkv("R7 skip status", st, 0);
    for (int k = 0; k < 4; k++) checkv("R7 memory unchanged", int'(mem[640+k]), int'(pat(640+k)));

    // R6: write then chained read
    clear_mem(); rec_len = 3; in_seed = 8'h70;
    put_ccw(0, 8'h01, 24'h100, F_CC, 16'd2);
    put_ccw(8, 8'h02, 24'h220, 8'h00, 16'd3);
    o0 = out_n; s0 = starts;
    run_prog(24'h0, 1'b0, st);
    checkv("R6 status", st, 0);
    checkv("R6 two device commands", starts - s0, 2);
    checkv("R6 write bytes", out_n - o0, 2);
    for (int k = 0; k < 3; k++) checkv("R6 chained read data", int'(mem[544+k]), 8'h70 + k);

    // R9: branch to another program, word after the branch not run
    clear_mem();
    put_ccw(0, 8'h08, 24'h040, 8'h00, 16'd0);
    put_ccw(8, 8'hFF, 24'h000, 8'h00, 16'd0);
    put_ccw(64, 8'h01, 24'h120, 8'h00, 16'd1);
    o0 = out_n; s0 = starts;
    run_prog(24'h0, 1'b0, st);
    checkv("R9 status", st, 0);
    checkv("R9 one command", starts - s0, 1);
    checkv("R9 byte out", int'(out_buf[o0]), int'(pat(288)));

    // R10: two branches in a row
    clear_mem();
    put_ccw(0, 8'h08, 24'h040, 8'h00, 16'd0);
    put_ccw(64, 8'h08, 24'h080, 8'h00, 16'd0);
    s0 = starts;
    run_prog(24'h0, 1'b0, st);
    checkv("R10 status", st, 2);
    checkv("R10 no command", starts - s0, 0);

    // R11: bad code and zero count
    clear_mem();
    put_ccw(0, 8'h05, 24'h100, 8'h00, 16'd2);
    run_prog(24'h0, 1'b0, st);
    checkv("R11 bad code status", st, 2);
    put_ccw(0, 8'h01, 24'h100, 8'h00, 16'd0);
    o0 = out_n;
    run_prog(24'h0, 1'b0, st);
    checkv("R11 zero count status", st, 2);
    checkv("R11 zero count moves nothing", out_n - o0, 0);

    // R2: start while busy is ignored
    clear_mem(); slow_rdy = 1'b1;
    put_ccw(0, 8'h01, 24'h300, 8'h00, 16'd8);
    put_ccw(64, 8'h01, 24'h100, F_CC, 16'd1);
    o0 = out_n; s0 = starts;
    run_prog(24'h0, 1'b1, st);
    checkv("R2 status", st, 0);
    checkv("R2 single command", starts - s0, 1);
    checkv("R2 byte count", out_n - o0, 8);
    for (int k = 0; k < 8; k++) checkv("R2 data from first program", int'(out_buf[o0+k]), int'(pat(768+k)));
    slow_rdy = 1'b0;

    // R8: record length sweep against count 4, suppress-length off/on
    for (int L = 1; L <= 6; L++) begin
      for (int s = 0; s < 2; s++) begin
        clear_mem(); rec_len = L; in_seed = 8'(8'h30 + L * 16);
        put_ccw(0, 8'h02, 24'h200, F_CC | (s != 0 ? F_SLI : 8'h00), 16'd4);
        put_ccw(8, 8'h01, 24'h300, 8'h00, 16'd1);
        o0 = out_n;
        run_prog(24'h0, 1'b0, st);
        exp_n  = (L < 4) ? L : 4;
        exp_st = (L != 4 && s == 0) ? 1 : 0;
        checkv("R8 status", st, exp_st);
        checkv("R8 chained write runs", out_n - o0, (exp_st == 0) ? 1 : 0);
        for (int k = 0; k < 4; k++)
          checkv("R8 stored bytes", int'(mem[512+k]),
                 (k < exp_n) ? int'(8'(in_seed + k)) : int'(pat(512+k)));
      end
    end

    finish_run();
  end
endmodule